// File: doc/BRIEF.md
# Nested-Loop DMA Destination Address Generator

This block produces the destination address stream for one DMA channel whose buffer is walked as up to four nested loops. A load strobe captures a start address, the byte length of the innermost row, a dimension count, and for each outer dimension a current count, a reload count and a signed stride. Every accepted beat moves the address forward by one beat width. At the end of a row the address also jumps by a signed stride and the row length starts again. Each outer counter steps down and refills from its reload value when it runs out.

The run ends when the outermost active dimension runs out. At that point the block raises a sticky done flag and ignores any further beats. A request-mask output can be armed to rise when a chosen loop level completes, so that the channel stops taking requests until the data has landed. It stays high until a destination-done pulse arrives. A descriptor with a zero count in a dimension it uses, or with a bad row length, is rejected at load with an error flag.

Top module: `mdma_addr_gen`

## Requirements
- R1: After reset and after every accepted load, done and mask are low. After a good load, `addr_o` equals the loaded start address and `active_o` is high.
- R2: Inside a row, each beat taken while active raises `addr_o` by BEAT_BYTES (8) on the next clock. Without a beat, or while not active, `addr_o` holds its value.
- R3: On the beat that empties the row (size is counted in bytes, BEAT_BYTES per beat), the row size reloads. The dimension-2 count steps down, and the address moves by BEAT_BYTES plus the dimension-2 stride.
- R4: When the row and the dimension-2 count run out on the same beat, only the dimension-3 stride is added, not the dimension-2 stride.
- R5: When the row, dimension 2 and dimension 3 all run out on the same beat of a 4-D walk, only the dimension-4 stride is added.
- R6: `dims_i` selects the number of dimensions (0 = 1-D, 1 = 2-D, 2 = 3-D, 3 = 4-D). On the beat where the highest active count runs out, `done_o` rises and `active_o` falls, and the address moves only by BEAT_BYTES. After that, beats leave the address and done unchanged until the next load.
- R7: A dimension count starts from its loaded current value. Once it runs out it refills from its reload value, so the first pass of a loop may differ in length from later passes.
- R8: A load raises `cfg_err_o` and leaves the block inactive in any of these cases:
  - the size is zero, or is not a multiple of BEAT_BYTES;
  - a current count of a used dimension is zero;
  - the reload count of dimension 2 is zero in 3-D or 4-D;
  - the reload count of dimension 3 is zero in 4-D.
  While inactive, beats do not move the address. A good load clears the error.
- R9: With mask enable set, `mask_o` rises after the beat that completes the selected level. The level codes are: 0 = row, 1 = dimension 2, 2 = dimension 3, 3 = dimension 4. A level above the active dimension count never raises it.
- R10: With mask enable clear, `mask_o` never rises.
- R11: Once high, `mask_o` stays high until a `dest_done_i` pulse. If a new mask event and `dest_done_i` fall in the same cycle, the mask stays high.
- R12: Strides are 28-bit two's-complement values and are sign-extended before they are added, so negative strides move the address down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture all descriptor inputs |
| start_addr_i | input | ADDR_W | First destination address |
| size_i | input | SIZE_W | Row length in bytes |
| dims_i | input | 2 | Number of dimensions minus one |
| cnt2_i | input | CNT_W | Dimension-2 initial count |
| bcnt2_i | input | CNT_W | Dimension-2 reload count |
| ofs2_i | input | OFS_W | Dimension-2 signed stride |
| cnt3_i | input | CNT_W | Dimension-3 initial count |
| bcnt3_i | input | CNT_W | Dimension-3 reload count |
| ofs3_i | input | OFS_W | Dimension-3 signed stride |
| cnt4_i | input | CNT_W | Dimension-4 count |
| ofs4_i | input | OFS_W | Dimension-4 signed stride |
| mask_en_i | input | 1 | Enable request masking |
| mask_dim_i | input | 2 | Level whose completion raises the mask |
| beat_i | input | 1 | One transfer beat accepted |
| dest_done_i | input | 1 | Data reached destination, clears the mask |
| addr_o | output | ADDR_W | Address of the current beat |
| active_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk complete (sticky until load) |
| mask_o | output | 1 | Mask further requests |
| cfg_err_o | output | 1 | Last load was rejected |

## Verification
The bench drives the address walk with descriptors of one, two, three and four dimensions. An independent nested-loop model predicts every beat address.

- A 2-D walk with a positive stride shows the row rollover.
- A 3-D walk uses a first-pass count that differs from the reload count and a negative outer stride. It separates a first-pass length bug, a missing sign extension and an adding of both strides on a joint rollover.
- The 4-D walk checks that only the outermost stride is applied when three counters expire together. It also checks that completion falls on exactly the last beat.
- Idle gaps between beats, extra beats after completion and rejected loads show that the address moves only on beats taken while active.
- Mask runs at the row level and the dimension-2 level, with masking disabled, and with a level above the active dimensions, show when the mask rises. A clear pulse arriving alone and in the same cycle as a new event shows what clears it.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
   localparam int MDMA_NDIM = 4;
   localparam int MDMA_DW   = $clog2(MDMA_NDIM);

   typedef enum logic [MDMA_DW-1:0] {
      LVL_ROW  = 2'd0,
      LVL_D2   = 2'd1,
      LVL_D3   = 2'd2,
      LVL_D4   = 2'd3
   } mdma_level_e;
endpackage

// File: rtl/mdma_dim_cnt.sv
module mdma_dim_cnt #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cur_ld_i,
   input  logic [CNT_W-1:0] base_ld_i,
   input  logic             step_i,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cur_q;
   logic [CNT_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         base_q <= '0;
      end else if (load_i) begin
         cur_q  <= cur_ld_i;
         base_q <= base_ld_i;
      end else if (step_i) begin
         cur_q  <= (cur_q == ONE) ? base_q : cur_q - ONE;
      end
   end

   assign last_o = (cur_q == ONE);
endmodule

// File: rtl/mdma_roll_dec.sv
module mdma_roll_dec
   import mdma_pkg::*;
#(
   parameter int NDIM = MDMA_NDIM,
   localparam int DW  = $clog2(NDIM)
) (
   input  logic            adv_i,
   input  logic [DW-1:0]   dims_i,
   input  logic [NDIM-1:0] last_i,
   input  logic            mask_en_i,
   input  logic [DW-1:0]   mask_dim_i,
   output logic [NDIM-2:0] step_o,
   output logic [NDIM-2:0] ofs_sel_o,
   output logic            fin_o,
   output logic            mask_hit_o
);
   logic [NDIM-1:0] roll;

   assign roll[0] = adv_i & last_i[0];

   for (genvar k = 1; k < NDIM; k++) begin : g_chain
      assign roll[k] = roll[k-1] & (dims_i >= DW'(k)) & last_i[k];
   end

   assign fin_o = roll[dims_i];

   for (genvar j = 0; j < NDIM-1; j++) begin : g_sel
      assign step_o[j]    = roll[j] & (dims_i > DW'(j));
      assign ofs_sel_o[j] = roll[j] & ~roll[j+1] & ~fin_o;
   end

   assign mask_hit_o = mask_en_i & roll[mask_dim_i];
endmodule

// File: rtl/mdma_ofs_add.sv
module mdma_ofs_add #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 28,
   parameter int NSEL   = 3,
   parameter int STEP   = 8
) (
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [NSEL-1:0][OFS_W-1:0]   ofs_i,
   input  logic [NSEL-1:0]              sel_i,
   output logic [ADDR_W-1:0]            addr_o
);
   logic [ADDR_W-1:0] delta;

   always_comb begin
      delta = ADDR_W'(STEP);
      for (int j = 0; j < NSEL; j++) begin
         if (sel_i[j]) delta = delta + ADDR_W'($signed(ofs_i[j]));
      end
   end

   assign addr_o = addr_i + delta;
endmodule

// File: rtl/mdma_addr_gen.sv
module mdma_addr_gen
   import mdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int CNT_W      = 12,
   parameter int OFS_W      = 28,
   parameter int BEAT_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [1:0]        dims_i,
   input  logic [CNT_W-1:0]  cnt2_i,
   input  logic [CNT_W-1:0]  bcnt2_i,
   input  logic [OFS_W-1:0]  ofs2_i,
   input  logic [CNT_W-1:0]  cnt3_i,
   input  logic [CNT_W-1:0]  bcnt3_i,
   input  logic [OFS_W-1:0]  ofs3_i,
   input  logic [CNT_W-1:0]  cnt4_i,
   input  logic [OFS_W-1:0]  ofs4_i,
   input  logic              mask_en_i,
   input  logic [1:0]        mask_dim_i,
   input  logic              beat_i,
   input  logic              dest_done_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              active_o,
   output logic              done_o,
   output logic              mask_o,
   output logic              cfg_err_o
);
   localparam int NDIM = MDMA_NDIM;
   localparam int NOUT = NDIM - 1;
   localparam logic [SIZE_W-1:0] SIZE_STEP = SIZE_W'(BEAT_BYTES);
   localparam logic [SIZE_W-1:0] ALIGN_MSK = SIZE_W'(BEAT_BYTES - 1);

   if (OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("mdma_addr_gen: OFS_W must be narrower than ADDR_W");
   end
   if ((BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
      $error("mdma_addr_gen: BEAT_BYTES must be a power of two");
   end
   if (SIZE_W <= $clog2(BEAT_BYTES)) begin : g_bad_size
      $error("mdma_addr_gen: SIZE_W too small for BEAT_BYTES");
   end

   logic [ADDR_W-1:0]          addr_q, addr_nx;
   logic [SIZE_W-1:0]          size_q, size_base_q;
   logic [1:0]                 dims_q, mask_dim_q;
   logic                       mask_en_q;
   logic [NOUT-1:0][OFS_W-1:0] ofs_q;
   logic                       active_q, done_q, mask_q, err_q;

   logic [NDIM-1:0]            last;
   logic [NOUT-1:0]            steps, ofs_sel;
   logic                       fin, mask_hit, adv, cfg_bad;
   logic [NOUT-1:0][CNT_W-1:0] cur_in, base_in;

   assign cur_in  = {cnt4_i, cnt3_i, cnt2_i};
   assign base_in = {cnt4_i, bcnt3_i, bcnt2_i};

   assign adv     = beat_i & active_q & ~load_i;
   assign last[0] = (size_q == SIZE_STEP);

   always_comb begin
      cfg_bad = (size_i == '0) || ((size_i & ALIGN_MSK) != '0);
      if (dims_i >= 2'd1 && cnt2_i == '0) cfg_bad = 1'b1;
      if (dims_i >= 2'd2 && (bcnt2_i == '0 || cnt3_i == '0)) cfg_bad = 1'b1;
      if (dims_i == 2'd3 && (bcnt3_i == '0 || cnt4_i == '0)) cfg_bad = 1'b1;
   end

   for (genvar j = 0; j < NOUT; j++) begin : g_dim
      mdma_dim_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load_i),
         .cur_ld_i  (cur_in[j]),
         .base_ld_i (base_in[j]),
         .step_i    (steps[j]),
         .last_o    (last[j+1])
      );
   end

   mdma_roll_dec #(.NDIM(NDIM)) u_dec (
      .adv_i      (adv),
      .dims_i     (dims_q),
      .last_i     (last),
      .mask_en_i  (mask_en_q),
      .mask_dim_i (mask_dim_q),
      .step_o     (steps),
      .ofs_sel_o  (ofs_sel),
      .fin_o      (fin),
      .mask_hit_o (mask_hit)
   );

   mdma_ofs_add #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .NSEL   (NOUT),
      .STEP   (BEAT_BYTES)
   ) u_add (
      .addr_i (addr_q),
      .ofs_i  (ofs_q),
      .sel_i  (ofs_sel),
      .addr_o (addr_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q      <= '0;
         size_q      <= '0;
         size_base_q <= '0;
         dims_q      <= '0;
         mask_dim_q  <= '0;
         mask_en_q   <= 1'b0;
         ofs_q       <= '0;
         active_q    <= 1'b0;
         done_q      <= 1'b0;
         mask_q      <= 1'b0;
         err_q       <= 1'b0;
      end else if (load_i) begin
         addr_q      <= start_addr_i;
         size_q      <= size_i;
         size_base_q <= size_i;
         dims_q      <= dims_i;
         mask_dim_q  <= mask_dim_i;
         mask_en_q   <= mask_en_i;
         ofs_q       <= {ofs4_i, ofs3_i, ofs2_i};
         active_q    <= ~cfg_bad;
         err_q       <= cfg_bad;
         done_q      <= 1'b0;
         mask_q      <= 1'b0;
      end else begin
         if (adv) begin
            addr_q <= addr_nx;
            size_q <= last[0] ? size_base_q : size_q - SIZE_STEP;
            if (fin) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
         if (mask_hit)         mask_q <= 1'b1;
         else if (dest_done_i) mask_q <= 1'b0;
      end
   end

   assign addr_o    = addr_q;
   assign active_o  = active_q;
   assign done_o    = done_q;
   assign mask_o    = mask_q;
   assign cfg_err_o = err_q;
endmodule

// File: rtl/mdma_addr_gen_chk.sv
module mdma_addr_gen_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              beat_i,
   input logic              dest_done_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              active_o,
   input logic              done_o,
   input logic              mask_o,
   input logic              cfg_err_o
);
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!done_o && !mask_o)); // R1

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !(beat_i && active_o)) |=> $stable(addr_o)); // R2

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !active_o); // R6

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !load_i) |=> (done_o && $stable(addr_o))); // R6

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (!active_o && !done_o)); // R8

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o && !dest_done_i && !load_i) |=> mask_o); // R11
endmodule

bind mdma_addr_gen mdma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_i      (load_i),
   .beat_i      (beat_i),
   .dest_done_i (dest_done_i),
   .addr_o      (addr_o),
   .active_o    (active_o),
   .done_o      (done_o),
   .mask_o      (mask_o),
   .cfg_err_o   (cfg_err_o)
);

// File: tb/mdma_addr_gen_test.sv
module mdma_addr_gen_test;
   localparam int CLK_NS = 10;
   localparam int BEAT   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic [15:0] size_i = '0;
   logic [1:0]  dims_i = '0;
   logic [11:0] cnt2_i = '0, bcnt2_i = '0, cnt3_i = '0, bcnt3_i = '0, cnt4_i = '0;
   logic [27:0] ofs2_i = '0, ofs3_i = '0, ofs4_i = '0;
   logic        mask_en_i = 1'b0;
   logic [1:0]  mask_dim_i = '0;
   logic        beat_i = 1'b0;
   logic        dest_done_i = 1'b0;
   logic [31:0] addr_o;
   logic        active_o, done_o, mask_o, cfg_err_o;

   logic [31:0] exp_q[$];
   logic [31:0] exp_final;
   string       cur_tag = "R2";
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   mdma_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
      .size_i(size_i), .dims_i(dims_i), .cnt2_i(cnt2_i), .bcnt2_i(bcnt2_i),
      .ofs2_i(ofs2_i), .cnt3_i(cnt3_i), .bcnt3_i(bcnt3_i), .ofs3_i(ofs3_i),
      .cnt4_i(cnt4_i), .ofs4_i(ofs4_i), .mask_en_i(mask_en_i),
      .mask_dim_i(mask_dim_i), .beat_i(beat_i), .dest_done_i(dest_done_i),
      .addr_o(addr_o), .active_o(active_o), .done_o(done_o), .mask_o(mask_o),
      .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // driver: captures a descriptor and pushes the expected beat addresses
   task automatic configure(input int start, input int size, input int dims,
                            input int c2, input int b2, input int o2,
                            input int c3, input int b3, input int o3,
                            input int c4, input int o4,
                            input bit men, input int mdim, input bit build);
      logic [31:0] a;
      int n2, n3, n4, nb;
      bit f2, f3;
      exp_q.delete();
      if (build) begin
         a = 32'(start); f2 = 1; f3 = 1; nb = size / BEAT;
         n4 = (dims == 3) ? c4 : 1;
         for (int i4 = 0; i4 < n4; i4++) begin
            n3 = (dims >= 2) ? (f3 ? c3 : b3) : 1; f3 = 0;
            for (int i3 = 0; i3 < n3; i3++) begin
               n2 = (dims >= 1) ? (f2 ? c2 : b2) : 1; f2 = 0;
               for (int i2 = 0; i2 < n2; i2++) begin
                  for (int i1 = 0; i1 < nb; i1++) begin
                     exp_q.push_back(a);
                     if (i1 < nb-1)      a = a + 32'(BEAT);
                     else if (i2 < n2-1) a = a + 32'(BEAT) + 32'(o2);
                     else if (i3 < n3-1) a = a + 32'(BEAT) + 32'(o3);
                     else if (i4 < n4-1) a = a + 32'(BEAT) + 32'(o4);
                     else                a = a + 32'(BEAT);
                  end
               end
            end
         end
         exp_final = a;
      end
      @(negedge clk);
      start_addr_i = 32'(start); size_i = 16'(size); dims_i = 2'(dims);
      cnt2_i = 12'(c2); bcnt2_i = 12'(b2); ofs2_i = 28'(o2);
      cnt3_i = 12'(c3); bcnt3_i = 12'(b3); ofs3_i = 28'(o3);
      cnt4_i = 12'(c4); ofs4_i = 28'(o4);
      mask_en_i = men; mask_dim_i = 2'(mdim);
      load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic run_beats(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         beat_i = 1'b1;
      end
      @(negedge clk);
      beat_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the expected address for every beat taken while active
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (beat_i && active_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected beat"}, addr_o, 0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(addr_o == e, {cur_tag, " beat address"}, addr_o, e);
            end
         end
      end
   end

   initial begin
      #(CLK_NS * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk(addr_o == 0 && !active_o, "R1 reset addr/active", {addr_o, 7'd0, active_o}, 0);
      chk(!done_o && !mask_o && !cfg_err_o, "R1 reset flags", {done_o, mask_o, cfg_err_o}, 0);

      // 1-D walk with idle gaps
      cur_tag = "R2";
      configure(32'h1000, 32, 0, 0,0,0, 0,0,0, 0,0, 0, 0, 1);
      chk(addr_o == 32'h1000 && active_o && !done_o, "R1 load state", addr_o, 32'h1000);
      run_beats(2);
      idle(3);
      chk(addr_o == 32'h1010, "R2 hold without beats", addr_o, 32'h1010);
      run_beats(2);
      chk(done_o && !active_o, "R6 1-D completion", {done_o, active_o}, 2'b10);
      chk(addr_o == exp_final, "R6 final address", addr_o, exp_final);
      run_beats(2);
      chk(done_o && addr_o == exp_final, "R6 beats after done ignored", addr_o, exp_final);
      chk(exp_q.size() == 0, "R6 all beats consumed", exp_q.size(), 0);

      // 2-D positive stride
      cur_tag = "R3";
      configure(32'h2000, 16, 1, 3,3,'h40, 0,0,0, 0,0, 0, 0, 1);
      run_beats(5);
      chk(!done_o, "R3 not done before last beat", done_o, 0);
      run_beats(1);
      chk(done_o && exp_q.size() == 0, "R3 2-D done", done_o, 1);

      // 3-D: first pass differs, negative strides
      cur_tag = "R4 R7 R12";
      configure(32'h8000, 16, 2, 2,3,-'h30, 2,2,-'h100, 0,0, 0, 0, 1);
      run_beats(9);
      chk(!done_o, "R7 first-pass length (9 beats)", done_o, 0);
      run_beats(1);
      chk(done_o, "R7 done at beat 10", done_o, 1);
      chk(addr_o == exp_final, "R12 final address", addr_o, exp_final);

      // 4-D
      cur_tag = "R5";
      configure(32'h10000, 16, 3, 2,3,'h20, 2,2,-'h80, 2,'h1000, 0, 0, 1);
      run_beats(21);
      chk(!done_o && active_o, "R5 active before last beat", done_o, 0);
      run_beats(1);
      chk(done_o && exp_q.size() == 0, "R5 4-D done", done_o, 1);
      chk(addr_o == exp_final, "R5 final address", addr_o, exp_final);

      // configuration errors
      cur_tag = "R8";
      configure(32'h3000, 16, 2, 2,0,0, 2,2,0, 0,0, 0, 0, 0);
      chk(cfg_err_o && !active_o, "R8 zero dim-2 reload in 3-D", cfg_err_o, 1);
      run_beats(2);
      chk(addr_o == 32'h3000, "R8 beats ignored while rejected", addr_o, 32'h3000);
      configure(32'h3000, 0, 0, 0,0,0, 0,0,0, 0,0, 0, 0, 0);
      chk(cfg_err_o, "R8 zero size", cfg_err_o, 1);
      configure(32'h3000, 12, 0, 0,0,0, 0,0,0, 0,0, 0, 0, 0);
      chk(cfg_err_o, "R8 misaligned size", cfg_err_o, 1);
      configure(32'h3000, 16, 3, 1,1,0, 1,1,0, 0,0, 0, 0, 0);
      chk(cfg_err_o, "R8 zero dim-4 count", cfg_err_o, 1);
      configure(32'h3000, 16, 0, 0,0,0, 0,0,0, 0,0, 0, 0, 1);
      chk(!cfg_err_o && active_o, "R8 good load clears error", cfg_err_o, 0);

      // mask at dimension-2 level
      cur_tag = "R9";
      configure(32'h4000, 16, 2, 2,3,'h10, 2,2,'h100, 0,0, 1, 1, 1);
      run_beats(3);
      chk(!mask_o, "R9 mask low before level end", mask_o, 0);
      run_beats(1);
      chk(mask_o, "R9 mask on dim-2 completion", mask_o, 1);
      run_beats(5);
      chk(mask_o, "R11 mask held without clear", mask_o, 1);
      @(negedge clk); dest_done_i = 1'b1;
      @(negedge clk); dest_done_i = 1'b0;
      chk(!mask_o, "R11 clear pulse drops mask", mask_o, 0);
      @(negedge clk); beat_i = 1'b1; dest_done_i = 1'b1;
      @(negedge clk); beat_i = 1'b0; dest_done_i = 1'b0;
      chk(mask_o, "R11 new event beats same-cycle clear", mask_o, 1);

      // mask at row level
      configure(32'h4000, 16, 2, 2,3,'h10, 2,2,'h100, 0,0, 1, 0, 1);
      run_beats(1);
      chk(!mask_o, "R9 row mask low mid-row", mask_o, 0);
      run_beats(1);
      chk(mask_o, "R9 row mask at row end", mask_o, 1);

      // level above active dims never masks
      configure(32'h4000, 16, 2, 2,3,'h10, 2,2,'h100, 0,0, 1, 3, 1);
      run_beats(10);
      chk(!mask_o && done_o, "R9 level above dims never masks", mask_o, 0);

      // masking disabled
      cur_tag = "R10";
      configure(32'h4000, 16, 2, 2,3,'h10, 2,2,'h100, 0,0, 0, 0, 1);
      for (int i = 0; i < 10; i++) begin
         run_beats(1);
         chk(!mask_o, "R10 mask disabled", mask_o, 0);
      end

      idle(2);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule